// File: doc/BRIEF.md
# Hit-Pattern Channel Readout Selector

This block sits behind a bank of per-channel discriminators in a multi-channel front-end. On every clock it counts how many discriminator outputs are set and compares that count against a programmable threshold. The count and the comparison together give a fast first-level trigger.

When a start pulse is accepted, the block freezes the discriminator bits into a hit register. That register is exposed so that a second-level trigger can inspect the pattern. The block also builds the set of channels to digitize, according to a readout mode and an optional neighbour expansion.

The selected channels then leave as a stream of channel indices, lowest index first, one per clock. The final index carries a last flag. If nothing is selected, a single empty-event marker is sent in place of the stream, so the downstream digitizer always sees a terminated event.

Top module: `hit_readout_sel`

## Requirements
- R1: A start pulse accepted while idle copies `hitIn` into `hitPattern` at that clock edge. `hitPattern` then holds its value until the next accepted start.
- R2: With `modeSel` = 2'b00, every channel 0 to 63 is selected, whatever the hits and the mask.
- R3: With `modeSel` = 2'b01, the selected channels are the latched hit channels, after any neighbour expansion.
- R4: With `modeSel` = 2'b10, the selected set is `chanMask` as sampled at the start edge. With `modeSel` = 2'b11, it is the union of the (expanded) hit channels and `chanMask`.
- R5: When `nbrEn` = 1, each hit also selects channel i-1 and channel i+1. There is no wrap-around: channel 0 has no lower neighbour and channel 63 has no upper neighbour. The expansion never applies to the mask.
- R6: From the cycle after the start edge, one selected index appears per cycle on `outIdx` with `outValid` = 1, in strictly ascending order. `outLast` = 1 marks the final index, and `outValid` is 0 in the cycle after it.
- R7: An empty selected set produces exactly one cycle with `outValid`, `outEmpty` and `outLast` all 1, then `outValid` returns to 0.
- R8: `multCount` equals the number of set bits of `hitIn`, with a latency of one clock.
- R9: `multTrig` is 1 exactly when the registered count is greater than or equal to `multThresh` as sampled at the same edge.
- R10: A start pulse that arrives while a stream or empty marker is being sent is ignored. The stream and `hitPattern` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitIn | input | 64 | Live discriminator bits, one per channel |
| start | input | 1 | Latch hits and begin readout (single-cycle pulse) |
| modeSel | input | 2 | 00 all, 01 hit, 10 mask, 11 hit or mask |
| nbrEn | input | 1 | Enable neighbour expansion of the hit pattern |
| chanMask | input | 64 | Channel set supplied on the fly |
| multThresh | input | 7 | Multiplicity trigger threshold |
| multCount | output | 7 | Registered count of set discriminators |
| multTrig | output | 1 | Count is at or above the threshold |
| hitPattern | output | 64 | Latched hit register |
| outValid | output | 1 | Stream entry present |
| outIdx | output | 6 | Channel index to digitize |
| outLast | output | 1 | Final entry of the event |
| outEmpty | output | 1 | Entry is an empty-event marker |

## Verification
The bench builds the block at its default width of 64 channels. At that width the two edge channels, 0 and 63, are reachable by the neighbour expansion. The full all-channels stream of 64 entries also runs, so the last flag is checked on the top index.

The 7-bit count reaches its maximum of 64, which makes the threshold test at equality and at the extreme meaningful. A mid-stream start in mask mode, with a different mask, would show as repeated or changed indices if the block did not ignore it.

// File: rtl/hit_readout_pkg.sv
package hit_readout_pkg;

  typedef enum logic [1:0] {
    MODE_ALL   = 2'b00,
    MODE_HIT   = 2'b01,
    MODE_MASK  = 2'b10,
    MODE_UNION = 2'b11
  } readMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EMIT,
    ST_EMPTY
  } rdState_e;

  typedef struct packed {
    logic load;     // capture hits and selection
    logic advance;  // drop lowest pending channel
  } rdCtrl_t;

endpackage

// File: rtl/hit_readout_dp.sv
module hit_readout_dp
  import hit_readout_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtrl_t           ctrl,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic [1:0]        modeSel,
  input  logic              nbrEn,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [CNT_W-1:0]  multThresh,
  output logic [CNT_W-1:0]  multCount,
  output logic              multTrig,
  output logic [NUM_CH-1:0] hitPattern,
  output logic [IDX_W-1:0]  curIdx,
  output logic              selEmpty,
  output logic              pendLast
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] expHits;
  logic [NUM_CH-1:0] selNext;
  logic [CNT_W-1:0]  liveCount;

  // neighbour expansion: shifts fill with zero, so no wrap at the edges
  always_comb begin
    expHits = hitIn;
    if (nbrEn) expHits = hitIn | (hitIn << 1) | (hitIn >> 1);
  end

  always_comb begin
    unique case (readMode_e'(modeSel))
      MODE_ALL:   selNext = '1;
      MODE_HIT:   selNext = expHits;
      MODE_MASK:  selNext = chanMask;
      default:    selNext = expHits | chanMask;
    endcase
  end

  assign selEmpty = (selNext == '0);
  assign pendLast = ((pend & (pend - 1'b1)) == '0);

  always_comb begin
    curIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend[i]) curIdx = i[IDX_W-1:0];
  end

  always_comb begin
    liveCount = '0;
    for (int i = 0; i < NUM_CH; i++)
      liveCount = liveCount + CNT_W'(hitIn[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      multCount <= '0;
      multTrig  <= 1'b0;
    end else begin
      multCount <= liveCount;
      multTrig  <= (liveCount >= multThresh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitPattern <= '0;
      pend       <= '0;
    end else if (ctrl.load) begin
      hitPattern <= hitIn;
      pend       <= selNext;
    end else if (ctrl.advance) begin
      pend       <= pend & (pend - 1'b1);
    end
  end

  // R6: consecutive stream entries rise strictly
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && $past(ctrl.advance)) |-> (curIdx > $past(curIdx)));

  // R6: an emitted index is always a member of the pending set
  a_r6_idx_in_set: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |-> pend[curIdx]);

  // R1: hit register only changes on an accepted start
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.load) |-> $stable(hitPattern));

  // R8: count can never exceed the channel total
  a_r8_mult_bound: assert property (@(posedge clk) disable iff (!rstN)
    multCount <= CNT_W'(NUM_CH));

endmodule

// File: rtl/hit_readout_ctl.sv
module hit_readout_ctl
  import hit_readout_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    selEmpty,
  input  logic    pendLast,
  output rdCtrl_t ctrl,
  output logic    outValid,
  output logic    outLast,
  output logic    outEmpty
);

  rdState_e state, stateNext;

  always_comb begin
    ctrl.load    = start && (state == ST_IDLE);
    ctrl.advance = (state == ST_EMIT);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = selEmpty ? ST_EMPTY : ST_EMIT;
      ST_EMIT:  if (pendLast) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign outValid = (state != ST_IDLE);
  assign outEmpty = (state == ST_EMPTY);
  assign outLast  = outEmpty || ((state == ST_EMIT) && pendLast);

  // R6/R7: a terminated event is followed by an idle cycle
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |=> !outValid);

  // R7: the empty marker always closes its event
  a_r7_empty_last: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> (outLast && outValid));

  // R10: start during a busy cycle does not reload
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !ctrl.load);

endmodule

// File: rtl/hit_readout_sel.sv
module hit_readout_sel
  import hit_readout_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic              start,
  input  logic [1:0]        modeSel,
  input  logic              nbrEn,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [CNT_W-1:0]  multThresh,
  output logic [CNT_W-1:0]  multCount,
  output logic              multTrig,
  output logic [NUM_CH-1:0] hitPattern,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic              outLast,
  output logic              outEmpty
);

  rdCtrl_t          ctrl;
  logic             selEmpty;
  logic             pendLast;
  logic [IDX_W-1:0] curIdx;

  hit_readout_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .selEmpty(selEmpty),
    .pendLast(pendLast), .ctrl(ctrl), .outValid(outValid),
    .outLast(outLast), .outEmpty(outEmpty)
  );

  hit_readout_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .hitIn(hitIn), .modeSel(modeSel),
    .nbrEn(nbrEn), .chanMask(chanMask), .multThresh(multThresh),
    .multCount(multCount), .multTrig(multTrig), .hitPattern(hitPattern),
    .curIdx(curIdx), .selEmpty(selEmpty), .pendLast(pendLast)
  );

  assign outIdx = outEmpty ? '0 : curIdx;

endmodule

// File: tb/hit_readout_sel_tb.sv
module hit_readout_sel_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] hitIn;
  logic        start;
  logic [1:0]  modeSel;
  logic        nbrEn;
  logic [63:0] chanMask;
  logic [6:0]  multThresh;
  logic [6:0]  multCount;
  logic        multTrig;
  logic [63:0] hitPattern;
  logic        outValid;
  logic [5:0]  outIdx;
  logic        outLast;
  logic        outEmpty;

  int vecCount = 0;
  int errCount = 0;

  always #10 clk = ~clk;

  hit_readout_sel u_dut (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .start(start), .modeSel(modeSel),
    .nbrEn(nbrEn), .chanMask(chanMask), .multThresh(multThresh),
    .multCount(multCount), .multTrig(multTrig), .hitPattern(hitPattern),
    .outValid(outValid), .outIdx(outIdx), .outLast(outLast), .outEmpty(outEmpty)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // live multiplicity and trigger, after at least one edge with stable inputs
  task automatic chkMult();
    int c = $countones(hitIn);
    chk("R8", "multCount", 64'(multCount), 64'(c));
    chk("R9", "multTrig", 64'(multTrig), 64'(c >= int'(multThresh)));
  endtask

  // behavioural model of the selected set
  function automatic logic [63:0] refSel(logic [63:0] h, logic [1:0] m,
                                         logic [63:0] mk, logic nb);
    logic [63:0] e = h;
    if (nb) begin
      for (int i = 0; i < 64; i++) begin
        if (h[i] && i > 0)  e[i-1] = 1'b1;
        if (h[i] && i < 63) e[i+1] = 1'b1;
      end
    end
    case (m)
      2'b00:   return '1;
      2'b01:   return e;
      2'b10:   return mk;
      default: return e | mk;
    endcase
  endfunction

  task automatic runEvent(string req, logic [63:0] h, logic [1:0] m,
                          logic [63:0] mk, logic nb, logic [6:0] th,
                          bit midStart);
    int q[$];
    logic [63:0] s = refSel(h, m, mk, nb);
    for (int i = 0; i < 64; i++) if (s[i]) q.push_back(i);
    if (q.size() == 0) q.push_back(-1);
    hitIn = h; modeSel = m; chanMask = mk; nbrEn = nb; multThresh = th;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < q.size(); k++) begin
      chk(req, "outValid", 64'(outValid), 64'(1));
      if (q[k] < 0) begin
        chk("R7", "outEmpty", 64'(outEmpty), 64'(1));
        chk("R7", "outLast", 64'(outLast), 64'(1));
      end else begin
        chk(req, "outIdx", 64'(outIdx), 64'(q[k]));
        chk(req, "outEmpty", 64'(outEmpty), 64'(0));
        chk("R6", "outLast", 64'(outLast), 64'(k == q.size() - 1));
      end
      chk(midStart ? "R10" : "R1", "hitPattern", hitPattern, h);
      chkMult();
      if (midStart && k == 0) begin
        chanMask = ~mk; start = 1'b1;   // R10: must be ignored
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk("R6", "outValid after last", 64'(outValid), 64'(0));
    chk("R1", "hitPattern held", hitPattern, h);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; hitIn = '0; modeSel = 2'b00; nbrEn = 1'b0;
    chanMask = '0; multThresh = 7'd1;
    repeat (3) @(negedge clk);
    chk("R6", "reset outValid", 64'(outValid), 64'(0));
    chk("R8", "reset multCount", 64'(multCount), 64'(0));
    chk("R9", "reset multTrig", 64'(multTrig), 64'(0));
    chk("R1", "reset hitPattern", hitPattern, 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // R2: all channels regardless of hits
    runEvent("R2", 64'h0000_0000_0000_0010, 2'b00, 64'h0, 1'b0, 7'd2, 1'b0);
    // R3: hit channels only, including both edges
    runEvent("R3", 64'h8000_0100_0000_0201, 2'b01, 64'hFFFF, 1'b0, 7'd4, 1'b0);
    // R5: neighbour expansion with edge channels, no wrap
    runEvent("R5", 64'h8000_0000_0010_0001, 2'b01, 64'h0, 1'b1, 7'd3, 1'b0);
    // R5: adjacent hits merge
    runEvent("R5", 64'h0000_0000_0000_6000, 2'b01, 64'h0, 1'b1, 7'd2, 1'b0);
    // R4: on-the-fly mask, hits ignored
    runEvent("R4", 64'hFFFF_0000_0000_0000, 2'b10, 64'h0000_00F0_0000_0003, 1'b1, 7'd16, 1'b0);
    // R4: union of expanded hits and mask
    runEvent("R4", 64'h0000_0000_0000_0100, 2'b11, 64'h4000_0000_0000_0001, 1'b1, 7'd1, 1'b0);
    // R7: empty selection in hit mode and in mask mode
    runEvent("R7", 64'h0, 2'b01, 64'hFFFF_FFFF, 1'b1, 7'd0, 1'b0);
    runEvent("R7", 64'h0000_0000_0000_0F00, 2'b10, 64'h0, 1'b0, 7'd5, 1'b0);
    // R9: all channels hit, threshold at maximum
    runEvent("R9", 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 64'h1, 1'b0, 7'd64, 1'b0);
    // R10: start mid-stream with a different mask
    runEvent("R10", 64'h0000_0000_0000_0005, 2'b10, 64'h0000_0000_0000_0E00, 1'b0, 7'd3, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule